// File: doc/BRIEF.md
# Segmented Paging Address Translator

This block turns a 32-bit virtual address into a 30-bit physical address in two steps. The top bits of the virtual address pick one of eight segment descriptors. Each descriptor holds the physical base address of a per-segment page table and the length of that table, counted in entries. The middle bits give a virtual page number. The block checks the page number against the selected segment's length. If the page number is in range, the block reads one 4-byte page-table entry from memory and joins the physical page number in that entry with the untouched 12-bit page offset.

Software loads the descriptors through a dedicated write port. The block takes a new virtual address only when it is idle. It issues one memory read over a valid/ready request channel and waits for a valid-qualified response. It then presents the result for exactly one cycle, either as a physical address or as a fault. An out-of-range page number faults at once and never reaches memory.

Top module: `seg_page_xlate`

## Requirements
- R1: The virtual address splits as segment index = bits 31:29, virtual page number = bits 28:12, and page offset = bits 11:0.
- R2: If the page number is greater than or equal to the selected segment's length, the result has res_fault=1 and res_pa=0, and no memory request is made.
- R3: The page-table entry address is the segment base plus four times the page number, taken modulo 2^30.
- R4: On a successful lookup, res_pa = {mem_rsp_data[17:0], offset} and res_fault=0. Bits 31:18 of the response are ignored.
- R5: After reset, every segment length is zero, so every translation faults. At the same time va_ready=1, res_valid=0 and mem_req_valid=0.
- R6: va_ready is high only while idle. A translation is accepted on a cycle where va_valid and va_ready are both high. A va_valid held high while the block is busy is not taken.
- R7: Once raised, mem_req_valid stays high with mem_req_addr stable until the cycle in which mem_req_ready is high. After that handshake it drops.
- R8: A write to descriptor i changes only descriptor i. A write made after a translation has been accepted does not affect that translation.
- R9: res_valid is a one-cycle pulse. It comes the cycle after acceptance on a fault, and the cycle after mem_rsp_valid on a lookup.
- R10: A mem_rsp_valid that arrives while no request is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | 3 | Descriptor index to write |
| cfg_base | input | 30 | Page-table physical base |
| cfg_len | input | 18 | Page-table length in entries |
| va_valid | input | 1 | Virtual address offered |
| va_ready | output | 1 | Block idle, will accept |
| va_addr | input | 32 | Virtual address |
| mem_req_valid | output | 1 | Page-table read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 30 | Byte address of the page-table entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Page-table entry |
| res_valid | output | 1 | Result pulse |
| res_fault | output | 1 | Bound violation |
| res_pa | output | 30 | Physical address |

## Verification
The bench sweeps every segment across page numbers from zero to just past the length. This catches a design that compares with > instead of >=. Such a design would let the last page plus one through, or fault on the last valid page. A segment whose base sits near the top of memory forces the entry address to wrap, which exposes a wrong shift or a wrong width. Request stalls, early spurious responses, descriptor writes during a lookup and a held va_valid target designs that drop a request, latch a stray response, read the table late, or accept a second address while busy.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
    localparam int VA_W      = 32;
    localparam int SEG_W     = 3;
    localparam int VPN_W     = 17;
    localparam int OFF_W     = 12;
    localparam int PPN_W     = 18;
    localparam int PTE_W     = 32;
    localparam int PTE_SHIFT = 2;
    localparam int PA_W      = PPN_W + OFF_W;
    localparam int LEN_W     = VPN_W + 1;
    localparam int NSEG      = 1 << SEG_W;

    typedef struct packed {
        logic [PA_W-1:0]  base;
        logic [LEN_W-1:0] len;
    } seg_desc_t;

    typedef struct packed {
        logic [SEG_W-1:0] seg;
        logic [VPN_W-1:0] vpn;
        logic [OFF_W-1:0] off;
    } vaddr_t;

    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_AWAIT, ST_DONE} xl_state_t;

    function automatic logic [PA_W-1:0] entry_addr(input logic [PA_W-1:0] base,
                                                   input logic [VPN_W-1:0] vpn);
        return base + (PA_W'(vpn) << PTE_SHIFT);
    endfunction

    function automatic logic out_of_range(input logic [VPN_W-1:0] vpn,
                                          input logic [LEN_W-1:0] len);
        return {1'b0, vpn} >= len;
    endfunction
endpackage

// File: rtl/seg_desc_file.sv
module seg_desc_file
    import seg_xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEG_W-1:0] widx,
    input  seg_desc_t        wdata,
    input  logic [SEG_W-1:0] ridx,
    output seg_desc_t        rdata
);
    seg_desc_t desc [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_desc
        always_ff @(posedge clk) begin
            if (rst) begin
                desc[g] <= '0;
            end else if (we && widx == SEG_W'(g)) begin
                desc[g] <= wdata;
            end
        end
    end

    assign rdata = desc[ridx];

    always_ff @(posedge clk) begin
        if (!rst && $past(rst)) begin
            p_len_cleared_r5: assert (desc[ridx].len == '0)
                else $error("descriptor length not cleared by reset");
        end
    end
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
    import seg_xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             va_valid,
    output logic             va_ready,
    input  vaddr_t           va,
    input  seg_desc_t        desc,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             res_valid,
    output logic             res_fault,
    output logic [PA_W-1:0]  res_pa
);
    xl_state_t        state;
    logic [PA_W-1:0]  addr_q;
    logic [OFF_W-1:0] off_q;
    logic             fault_q;
    logic [PA_W-1:0]  pa_q;
    logic             take;
    logic             unused_pte_hi;

    assign take          = va_valid && state == ST_IDLE;
    assign unused_pte_hi = ^mem_rsp_data[PTE_W-1:PPN_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            off_q   <= '0;
            fault_q <= 1'b0;
            pa_q    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (take) begin
                    off_q <= va.off;
                    if (out_of_range(va.vpn, desc.len)) begin
                        fault_q <= 1'b1;
                        pa_q    <= '0;
                        state   <= ST_DONE;
                    end else begin
                        fault_q <= 1'b0;
                        addr_q  <= entry_addr(desc.base, va.vpn);
                        state   <= ST_ISSUE;
                    end
                end
                ST_ISSUE: if (mem_req_ready) state <= ST_AWAIT;
                ST_AWAIT: if (mem_rsp_valid) begin
                    pa_q  <= {mem_rsp_data[PPN_W-1:0], off_q};
                    state <= ST_DONE;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign va_ready      = state == ST_IDLE;
    assign mem_req_valid = state == ST_ISSUE;
    assign mem_req_addr  = addr_q;
    assign res_valid     = state == ST_DONE;
    assign res_fault     = fault_q;
    assign res_pa        = pa_q;

    p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
    p_req_drop_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_ready |=> !mem_req_valid);
    p_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);
    p_fault_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_fault |-> !mem_req_valid && res_pa == '0);
    p_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid || res_valid) |-> !va_ready);
    p_rsp_done_r9: assert property (@(posedge clk) disable iff (rst)
        state == ST_AWAIT && mem_rsp_valid |=> res_valid && !res_fault);
endmodule

// File: rtl/seg_page_xlate.sv
module seg_page_xlate
    import seg_xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [SEG_W-1:0] cfg_idx,
    input  logic [PA_W-1:0]  cfg_base,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             va_valid,
    output logic             va_ready,
    input  logic [VA_W-1:0]  va_addr,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             res_valid,
    output logic             res_fault,
    output logic [PA_W-1:0]  res_pa
);
    vaddr_t    va;
    seg_desc_t wdesc;
    seg_desc_t rdesc;

    assign va    = vaddr_t'(va_addr);
    assign wdesc = '{base: cfg_base, len: cfg_len};

    seg_desc_file u_desc (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .widx  (cfg_idx),
        .wdata (wdesc),
        .ridx  (va.seg),
        .rdata (rdesc)
    );

    xlate_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .va_valid      (va_valid),
        .va_ready      (va_ready),
        .va            (va),
        .desc          (rdesc),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .res_valid     (res_valid),
        .res_fault     (res_fault),
        .res_pa        (res_pa)
    );
endmodule

// File: tb/seg_page_xlate_bench.sv
module seg_page_xlate_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [29:0] cfg_base = '0;
    logic [17:0] cfg_len = '0;
    logic        va_valid = 1'b0;
    logic        va_ready;
    logic [31:0] va_addr = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [29:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        res_valid;
    logic        res_fault;
    logic [29:0] res_pa;

    int     n_chk = 0;
    int     n_bad = 0;
    bit     finished = 0;
    longint base_m [8];
    longint len_m  [8];

    always #5 clk = ~clk;

    seg_page_xlate u_seg_page_xlate (.*);

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pte_of(input longint a);
        return 32'((a * 13) + 64'hA5A5_0000);
    endfunction

    task automatic wr_desc(input int i, input longint b, input longint l);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(i); cfg_base = 30'(b); cfg_len = 18'(l);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic xlate(input int seg, input longint vpn, input longint off,
                         input int stall, input int lat, input bit clob);
        bit          flt;
        logic [29:0] ea;
        logic [31:0] pte;
        logic [29:0] epa;
        flt = vpn >= len_m[seg];
        ea  = 30'(base_m[seg] + vpn * 4);
        pte = pte_of(ea);
        epa = {pte[17:0], 12'(off)};
        @(negedge clk);
        va_valid = 1'b1;
        va_addr  = {3'(seg), 17'(vpn), 12'(off)};
        @(negedge clk);
        va_valid = 1'b0;
        if (flt) begin
            chk(res_valid && res_fault, "R2 fault result", {res_valid, res_fault}, 3);
            chk(res_pa == 0, "R2 fault pa zero", res_pa, 0);
            chk(!mem_req_valid, "R2 no memory access", mem_req_valid, 0);
            @(negedge clk);
            chk(!res_valid && va_ready, "R9 single fault pulse", {res_valid, va_ready}, 1);
            return;
        end
        if (clob) begin
            cfg_we = 1'b1; cfg_idx = 3'(seg);
            cfg_base = 30'(base_m[seg] ^ 64'h0123_4000); cfg_len = '0;
        end
        chk(mem_req_valid, "R7 request raised", mem_req_valid, 1);
        chk(mem_req_addr == ea, "R3 entry address", mem_req_addr, ea);
        for (int s = 0; s < stall; s++) begin
            mem_rsp_valid = 1'b1; mem_rsp_data = 32'hDEAD_BEEF;
            @(negedge clk);
            cfg_we = 1'b0; mem_rsp_valid = 1'b0;
            chk(mem_req_valid && mem_req_addr == ea, "R7 held under stall", mem_req_addr, ea);
            chk(!res_valid, "R10 stray response ignored", res_valid, 0);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0; cfg_we = 1'b0;
        chk(!mem_req_valid && !res_valid, "R7 request dropped", {mem_req_valid, res_valid}, 0);
        for (int w = 0; w < lat; w++) begin
            va_valid = 1'b1; va_addr = ~va_addr;
            @(negedge clk);
            chk(!va_ready && !res_valid, "R6 busy refuses", {va_ready, res_valid}, 0);
        end
        va_valid = 1'b0;
        mem_rsp_valid = 1'b1; mem_rsp_data = pte;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        chk(res_valid && !res_fault, "R9 result after response", {res_valid, res_fault}, 2);
        chk(res_pa == epa, clob ? "R8 in-flight write ignored" : "R4 physical address", res_pa, epa);
        @(negedge clk);
        chk(!res_valid && va_ready, "R6 back to idle", {res_valid, va_ready}, 1);
        if (clob) wr_desc(seg, base_m[seg], len_m[seg]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(va_ready && !res_valid && !mem_req_valid, "R5 idle after reset",
            {va_ready, res_valid, mem_req_valid}, 4);
        for (int i = 0; i < 8; i++) begin
            base_m[i] = 0; len_m[i] = 0;
            xlate(i, 0, 12'h5A5, 0, 0, 0);
            xlate(i, 17'h1FFFF, 0, 0, 0, 0);
        end
        for (int i = 0; i < 7; i++) begin
            base_m[i] = (i * 64'h0500_0040 + 64'h10) & 64'h3FFF_FFFF;
            len_m[i]  = i * 3;
            wr_desc(i, base_m[i], len_m[i]);
        end
        base_m[7] = 64'h3FFF_FFF0; len_m[7] = 64'h20000;
        wr_desc(7, base_m[7], len_m[7]);
        // R1 sweep: every segment, page numbers up to just past the length
        for (int i = 0; i < 7; i++)
            for (int v = 0; v <= len_m[i] + 1; v++)
                xlate(i, v, (v * 64'h9D + i * 64'h111) & 64'hFFF, v % 3, (v + i) % 3, 0);
        xlate(3, 17'h1FFFF, 12'hFFF, 0, 0, 0);
        // R3 wrap near the top of memory, full-range segment
        xlate(7, 0, 12'h000, 1, 1, 0);
        xlate(7, 5, 12'h123, 0, 2, 0);
        xlate(7, 17'h1FFFF, 12'hFFF, 2, 0, 0);
        // R8 descriptor rewritten while the lookup is in flight
        xlate(6, 4, 12'h0AB, 2, 1, 1);
        xlate(6, 4, 12'h0AB, 0, 0, 0);
        xlate(5, 14, 12'h777, 1, 1, 1);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule